// File: doc/BRIEF.md
# Four-Channel Rotating Priority Arbiter

This block chooses which of four transfer request lines is served next by a transfer controller. Each channel has a request line and a mask bit. A mask bit that is set removes that channel from the choice. One configuration bit selects the priority scheme. In fixed mode channel 0 always beats channel 1, channel 1 beats channel 2, and channel 3 ranks last. In rotating mode the channel that was just granted falls to the bottom of the order, and the channel numbered one above it (wrapping from 3 to 0) moves to the top. This keeps any single channel from holding the bus indefinitely.

The choice is not made continuously. The arbiter makes a decision only when the host hands the bus over, which is seen as the hold-acknowledge input going from low to high. The winning channel is then held on a one-hot grant output, together with a valid flag. The grant stays fixed while the service runs. The service ends when the host withdraws hold-acknowledge or when the granted channel drops its request. A new decision needs a fresh rising hold-acknowledge.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grant is 0000 and grant_valid is low, and the rotation pointer selects channel 0 as the highest priority.
- R2: With rotate_sel = 0 (fixed mode), a decision grants the lowest-numbered eligible channel, whatever channels were served before.
- R3: With rotate_sel = 1 (rotating mode), after channel k is granted, the next decision ranks channel (k+1) mod 4 highest and channel k lowest. For example, after channel 1 the order is 2, 3, 0, 1. The pointer moves only on rotating-mode grants.
- R4: A decision is taken only on the clock edge where hold_ack is sampled high after being low on the previous edge. The grant is visible after that edge. At no other time can a grant appear, even if requests are pending.
- R5: Bit i of mask set to 1 makes channel i ineligible, so that channel is never granted and its request is ignored.
- R6: grant is one-hot or zero, with bit i meaning channel i, and grant_valid is high exactly when grant is nonzero.
- R7: While hold_ack stays high and the granted channel's request stays high, grant does not change, even if other requests or mask bits change. If either signal drops, grant and grant_valid clear on the next clock edge.
- R8: If no channel is eligible at a decision, grant_valid stays low and the rotation pointer keeps its value.
- R9: In rotating mode, a channel that keeps requesting while unmasked is granted within four decisions, so at most three other services come before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_CH | Request line per channel |
| mask | input | NUM_CH | Mask bit per channel; 1 removes the channel from arbitration |
| rotate_sel | input | 1 | 0 = fixed priority, 1 = rotating priority |
| hold_ack | input | 1 | Host bus hand-over; its rising transition triggers a decision |
| grant | output | NUM_CH | One-hot grant of the channel being served |
| grant_valid | output | 1 | High while a grant is held |

## Verification
The main decision is exercised with several request patterns. All four channels requesting in fixed mode shows that the order never moves. All four requesting in rotating mode, repeated, shows the pointer stepping and wrapping from 3 back to 0. Sparse patterns show that ineligible channels are skipped from any pointer position. A masked-only request shows that an empty decision leaves the pointer alone. Extra requests raised in the middle of a service, or while hold_ack stays high with no service running, show that the decision stays frozen between hand-overs. A run in which every channel requests shows the bound on waiting.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;

endpackage

// File: rtl/arb_hold_edge.sv
module arb_hold_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_ack,
    output logic rise
);

    logic hold_d;
    logic hold_q;

    always_comb begin
        hold_d = hold_ack;
        rise   = hold_ack && !hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R4
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_CH = 4,
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [PTR_W-1:0]  base,
    output logic              found,
    output logic [PTR_W-1:0]  idx
);

    logic [PTR_W-1:0] pos [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pos
        logic [PTR_W:0] sum;
        assign sum    = {1'b0, base} + (PTR_W+1)'(g);
        assign pos[g] = (int'(sum) >= NUM_CH) ? PTR_W'(int'(sum) - NUM_CH)
                                              : PTR_W'(sum);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[pos[i]]) begin
                found = 1'b1;
                idx   = pos[i];
            end
        end
    end

endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec #(
    parameter int NUM_CH = 4,
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [PTR_W-1:0]  idx,
    input  logic              en,
    output logic [NUM_CH-1:0] onehot
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign onehot[g] = en && (idx == PTR_W'(g));
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] mask,
    input  logic              rotate_sel,
    input  logic              hold_ack,
    output logic [NUM_CH-1:0] grant,
    output logic              grant_valid
);

    typedef struct packed {
        logic [NUM_CH-1:0] grant;
        logic              valid;
        logic [PTR_W-1:0]  ptr;
    } arb_st_t;

    arb_st_t st_d;
    arb_st_t st_q;

    prio_mode_e        mode;
    logic              rise;
    logic [NUM_CH-1:0] elig;
    logic [PTR_W-1:0]  base;
    logic              found;
    logic [PTR_W-1:0]  win_idx;
    logic [NUM_CH-1:0] win_onehot;
    logic [PTR_W-1:0]  next_ptr;
    logic              keep_svc;

    assign mode = prio_mode_e'(rotate_sel);
    assign elig = req & ~mask;
    assign base = (mode == PRIO_ROTATE) ? st_q.ptr : '0;

    arb_hold_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_ack (hold_ack),
        .rise     (rise)
    );

    arb_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig  (elig),
        .base  (base),
        .found (found),
        .idx   (win_idx)
    );

    arb_grant_dec #(.NUM_CH(NUM_CH)) u_dec (
        .idx    (win_idx),
        .en     (found),
        .onehot (win_onehot)
    );

    assign next_ptr = (int'(win_idx) == NUM_CH - 1) ? '0 : win_idx + PTR_W'(1);
    assign keep_svc = hold_ack && (|(req & st_q.grant));

    always_comb begin
        st_d = st_q;
        if (st_q.valid) begin
            if (!keep_svc) begin
                st_d.grant = '0;
                st_d.valid = 1'b0;
            end
        end else if (rise && found) begin
            st_d.grant = win_onehot;
            st_d.valid = 1'b1;
            if (mode == PRIO_ROTATE) begin
                st_d.ptr = next_ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant       = st_q.grant;
    assign grant_valid = st_q.valid;

    // R6
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grant) && (st_q.valid == (|st_q.grant)));

    // R4
    no_grant_without_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && !rise) |=> !st_q.valid);

    // R5
    masked_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && rise) |=> ((st_q.grant & $past(mask)) == '0));

    // R8
    idle_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && rise && (elig == '0)) |=> (!st_q.valid && $stable(st_q.ptr)));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && hold_ack && (|(req & st_q.grant))) |=> (st_q.valid && $stable(st_q.grant)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !hold_ack) |=> !st_q.valid);

endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] mask = '0;
    logic       rotate_sel = 1'b0;
    logic       hold_ack = 1'b0;
    logic [3:0] grant;
    logic       grant_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    dma_prio_arbiter #(.NUM_CH(4)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .mask        (mask),
        .rotate_sel  (rotate_sel),
        .hold_ack    (hold_ack),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_tests++;
                if (grant !== it.exp || grant_valid !== (|it.exp)) begin
                    n_fail++;
                    $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                             it.tag, grant, grant_valid, it.exp, |it.exp);
                end
            end
        end
    end

    task automatic expect_now(input logic [3:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    // one hand-over: inputs set with hold low, then hold raised
    task automatic decide(input logic [3:0] r, input logic [3:0] m, input logic rot,
                          input logic [3:0] exp, input string tag);
        @(negedge clk);
        req = r; mask = m; rotate_sel = rot; hold_ack = 1'b0;
        @(negedge clk);
        hold_ack = 1'b1;
        @(negedge clk);
        expect_now(exp, tag);
    endtask

    task automatic end_service(input string tag);
        @(negedge clk);
        hold_ack = 1'b0;
        @(negedge clk);
        expect_now(4'b0000, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_now(4'b0000, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_now(4'b0000, "R1 after reset");

        // fixed mode
        decide(4'b1111, 4'b0000, 1'b0, 4'b0001, "R2 fixed all requesting");
        end_service("R7 hold drop clears");
        decide(4'b1111, 4'b0000, 1'b0, 4'b0001, "R2 fixed no rotation");
        end_service("R7 hold drop clears");
        decide(4'b1100, 4'b0000, 1'b0, 4'b0100, "R2 fixed lowest eligible");
        end_service("R7 hold drop clears");
        decide(4'b0110, 4'b0010, 1'b0, 4'b0100, "R5 masked channel skipped");
        end_service("R7 hold drop clears");

        // rotating mode, pointer starts at 0 (R1)
        decide(4'b1111, 4'b0000, 1'b1, 4'b0001, "R1 R3 rotate first pick ch0");
        end_service("R7 hold drop clears");
        decide(4'b1111, 4'b0000, 1'b1, 4'b0010, "R3 rotate ch1");
        end_service("R7 hold drop clears");
        decide(4'b1111, 4'b0000, 1'b1, 4'b0100, "R3 after ch1 ch2 highest");
        end_service("R7 hold drop clears");
        decide(4'b1011, 4'b0000, 1'b1, 4'b1000, "R3 rotate ch3");
        end_service("R7 hold drop clears");

        // empty decision, pointer must stay at 0
        decide(4'b0001, 4'b0001, 1'b1, 4'b0000, "R8 no eligible request");
        end_service("R8 stays idle");
        decide(4'b1110, 4'b0000, 1'b1, 4'b0010, "R8 pointer kept ch1 wins");

        // frozen during service
        @(negedge clk);
        req = 4'b1111; mask = 4'b0100;
        repeat (2) @(negedge clk);
        expect_now(4'b0010, "R7 grant stable mid-service");
        req = 4'b1101;
        @(negedge clk);
        expect_now(4'b0000, "R7 request drop clears");
        repeat (3) @(negedge clk);
        expect_now(4'b0000, "R4 no decision while hold stays high");
        hold_ack = 1'b0;
        mask = 4'b0000;
        req = 4'b1111;
        repeat (3) @(negedge clk);
        expect_now(4'b0000, "R4 no decision while hold low");

        decide(4'b1111, 4'b0000, 1'b1, 4'b0100, "R3 pointer after ch1");
        end_service("R7 hold drop clears");

        // starvation bound: pointer at 3, channel 2 must win within 4 decisions
        begin
            int  cnt = 0;
            bit  got = 1'b0;
            for (int k = 0; k < 4 && !got; k++) begin
                @(negedge clk);
                req = 4'b1111; mask = 4'b0000; rotate_sel = 1'b1; hold_ack = 1'b0;
                @(negedge clk);
                hold_ack = 1'b1;
                @(negedge clk);
                cnt++;
                if (grant[2]) got = 1'b1;
                @(negedge clk);
                hold_ack = 1'b0;
            end
            n_tests++;
            if (!got) begin
                n_fail++;
                $display("FAIL R9: channel 2 not served after %0d decisions, expected within 4", cnt);
            end
        end

        decide(4'b1111, 4'b0000, 1'b0, 4'b0001, "R2 fixed ignores pointer");
        end_service("R7 hold drop clears");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule